// File: doc/BRIEF.md
# SD Card SPI-Mode Command Engine

This block issues a single command to a memory card attached over SPI and gathers the card's reply. A host pulses `start` with a 6-bit command index, a 32-bit argument, the reply length in bytes, an optional exact-match value and a busy-wait flag. The engine emits a seven-byte command frame with a CRC7 computed as the bytes go out. It then skips one byte and polls for the first reply byte. It gathers the remaining reply bytes and, if asked, waits until the card stops signalling busy.

Chip select and the serial bit shifter are outside the block. The engine exchanges one byte at a time with them. It holds `byte_req` high with the byte to send on `byte_tx`. Each cycle in which `byte_ack` is high completes one exchange, and in that cycle `byte_rx` carries the byte clocked in from the card. When the command ends, `done` pulses for one cycle. `resp` and `timeout` then hold the outcome until the next command starts.

Top module: `sd_spi_cmd_engine`

## Requirements
- R1: Each command sends exactly seven bytes in this order: 0xFF, then 0x40 OR the command index, then the argument from bits 31:24 down to bits 7:0, then the CRC byte.
- R2: The CRC byte equals the CRC7 (polynomial x^7+x^3+1, initial value 0) over frame bytes two to six, placed in bits 7:1, with bit 0 set to 1. CMD0 with argument 0 gives 0x95, and CMD8 with argument 0x1AA gives 0x87.
- R3: The byte received right after the frame (exchange 8) is ignored even if it would qualify.
- R4: With matching off, polling ends at the first received byte whose bit 7 is 0. At most POLL_LIMIT (8) bytes are polled, so a byte that qualifies in the last poll slot is still accepted.
- R5: With matching on, polling ends only at a byte equal to `match_val`. A byte that merely has bit 7 clear does not end it.
- R6: If no byte qualifies within the poll limit, `timeout` is 1, `resp` is all zeros, and no further byte is exchanged.
- R7: The qualifying byte is reply byte 0, placed in `resp[39:32]`. The following reply bytes fill `resp[31:24]`, `resp[23:16]` and so on, up to `resp_len` bytes. Unused bytes read 0.
- R8: With busy-wait on, after the last reply byte the engine keeps reading until a nonzero byte arrives. It then finishes with `timeout` 0.
- R9: If busy-wait sees BUSY_LIMIT zero bytes in a row, the engine finishes with `timeout` 1 and keeps the captured reply.
- R10: Every byte sent after the frame is 0xFF.
- R11: `done` is high for exactly one cycle per command. A `start` that arrives while a command is in progress is ignored.
- R12: After reset, `byte_req`, `done` and `timeout` are 0 and `resp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (taken only when idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_len | input | 3 | Reply length in bytes (1 to 5) |
| match_en | input | 1 | Use exact match instead of the bit-7 test |
| match_val | input | 8 | Value that ends polling when matching is on |
| busy_wait | input | 1 | Wait for a nonzero byte after the reply |
| byte_req | output | 1 | Byte exchange requested |
| byte_tx | output | 8 | Byte to send |
| byte_ack | input | 1 | Exchange complete this cycle |
| byte_rx | input | 8 | Byte received, valid with byte_ack |
| resp | output | 40 | Reply bytes, byte 0 in the top eight bits |
| done | output | 1 | One-cycle end-of-command pulse |
| timeout | output | 1 | Poll or busy limit exceeded |

## Verification
The assertions assume that the byte shifter acknowledges only while `byte_req` is high, and that `start` may arrive at any time. Under those assumptions they check that a request holds until it is acknowledged and that the latched command stays unchanged while a command runs. They also check that polling and busy-waiting never exceed their limits. The stimulus acknowledges on the falling edge, one exchange every second cycle, and only while a request is pending. It also issues a deliberate `start` partway through a frame. The bench lowers BUSY_LIMIT so that the busy timeout can be reached.

// File: rtl/sd_spi_cmd_engine.sv
module sd_spi_cmd_engine #(
  parameter int POLL_LIMIT = 8,
  parameter int BUSY_LIMIT = 3000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic [2:0]  resp_len,
  input  logic        match_en,
  input  logic [7:0]  match_val,
  input  logic        busy_wait,
  output logic        byte_req,
  output logic [7:0]  byte_tx,
  input  logic        byte_ack,
  input  logic [7:0]  byte_rx,
  output logic [39:0] resp,
  output logic        done,
  output logic        timeout
);
  localparam int CNT_MAX = (BUSY_LIMIT > POLL_LIMIT) ? BUSY_LIMIT : POLL_LIMIT;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [2:0] S_IDLE = 3'd0, S_FRAME = 3'd1, S_DROP = 3'd2, S_POLL = 3'd3,
                         S_GATH = 3'd4, S_BUSY = 3'd5, S_FIN = 3'd6;

  logic [2:0]    st;
  logic [CW-1:0] cnt;
  logic [2:0]    fidx, ridx, len_q, len_in;
  logic [5:0]    cmd_q;
  logic [31:0]   arg_q;
  logic          men_q, bw_q, to_q;
  logic [7:0]    mval_q, frame_b;
  logic [6:0]    crc_q;
  logic [39:0]   resp_q;
  logic          xfer, qualify, last_resp;

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic [7:0] d);
    logic [6:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[6] ^ d[i];
      r = {r[5:0], 1'b0};
      if (fb) r = r ^ 7'h09;
    end
    return r;
  endfunction

  always_comb begin
    case (fidx)
      3'd0:    frame_b = 8'hFF;
      3'd1:    frame_b = {2'b01, cmd_q};
      3'd2:    frame_b = arg_q[31:24];
      3'd3:    frame_b = arg_q[23:16];
      3'd4:    frame_b = arg_q[15:8];
      3'd5:    frame_b = arg_q[7:0];
      default: frame_b = {crc_q, 1'b1};
    endcase
  end

  assign len_in    = (resp_len == 3'd0) ? 3'd1 : (resp_len > 3'd5) ? 3'd5 : resp_len;
  assign byte_req  = (st != S_IDLE) && (st != S_FIN);
  assign byte_tx   = (st == S_FRAME) ? frame_b : 8'hFF;
  assign xfer      = byte_req && byte_ack;
  assign qualify   = men_q ? (byte_rx == mval_q) : !byte_rx[7];
  assign last_resp = (ridx == len_q - 3'd1);
  assign resp      = resp_q;
  assign done      = (st == S_FIN);
  assign timeout   = to_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; fidx <= '0; ridx <= '0; len_q <= 3'd1;
      cmd_q <= '0; arg_q <= '0; men_q <= 1'b0; mval_q <= '0; bw_q <= 1'b0;
      crc_q <= '0; resp_q <= '0; to_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cmd_q <= cmd_idx; arg_q <= cmd_arg; len_q <= len_in;
          men_q <= match_en; mval_q <= match_val; bw_q <= busy_wait;
          cnt <= '0; fidx <= '0; ridx <= '0; crc_q <= '0;
          resp_q <= '0; to_q <= 1'b0; st <= S_FRAME;
        end
        S_FRAME: if (xfer) begin
          if (fidx >= 3'd1 && fidx <= 3'd5) crc_q <= crc7_step(crc_q, frame_b);
          if (fidx == 3'd6) st <= S_DROP;
          else fidx <= fidx + 3'd1;
        end
        S_DROP: if (xfer) begin
          cnt <= '0; st <= S_POLL;
        end
        S_POLL: if (xfer) begin
          if (qualify) begin
            resp_q[39:32] <= byte_rx;
            ridx <= 3'd1;
            cnt <= '0;
            if (len_q == 3'd1) st <= bw_q ? S_BUSY : S_FIN;
            else st <= S_GATH;
          end else if (cnt == CW'(POLL_LIMIT - 1)) begin
            to_q <= 1'b1; st <= S_FIN;
          end else cnt <= cnt + 1'b1;
        end
        S_GATH: if (xfer) begin
          resp_q[39 - 8*ridx -: 8] <= byte_rx;
          if (last_resp) st <= bw_q ? S_BUSY : S_FIN;
          else ridx <= ridx + 3'd1;
        end
        S_BUSY: if (xfer) begin
          if (byte_rx != 8'h00) st <= S_FIN;
          else if (cnt == CW'(BUSY_LIMIT - 1)) begin
            to_q <= 1'b1; st <= S_FIN;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_spi_cmd_engine_chk.sv
module sd_spi_cmd_engine_chk #(
  parameter int POLL_LIMIT = 8,
  parameter int BUSY_LIMIT = 3000000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_req,
  input logic        byte_ack,
  input logic [7:0]  byte_tx,
  input logic        done,
  input logic [2:0]  st,
  input logic [5:0]  cmd_q,
  input logic [31:0] arg_q
);
  int pcnt, bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= 0; bcnt <= 0;
    end else begin
      pcnt <= (st == 3'd3) ? pcnt + ((byte_req && byte_ack) ? 1 : 0) : 0;
      bcnt <= (st == 3'd5) ? bcnt + ((byte_req && byte_ack) ? 1 : 0) : 0;
    end
  end

  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req && !byte_ack |=> byte_req);
  p_poll_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= POLL_LIMIT);
  p_busy_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= BUSY_LIMIT);
  p_filler_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req && st != 3'd1 |-> byte_tx == 8'hFF);
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |=> $stable(cmd_q) && $stable(arg_q));
endmodule

bind sd_spi_cmd_engine sd_spi_cmd_engine_chk #(.POLL_LIMIT(POLL_LIMIT), .BUSY_LIMIT(BUSY_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_req(byte_req), .byte_ack(byte_ack), .byte_tx(byte_tx),
  .done(done), .st(st), .cmd_q(cmd_q), .arg_q(arg_q)
);

// File: tb/test_sd_spi_cmd_engine.sv
`timescale 1ns/1ps
module test_sd_spi_cmd_engine;
  localparam int BL = 20;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [5:0] cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [2:0] resp_len = 3'd1;
  logic match_en = 1'b0, busy_wait = 1'b0, byte_ack = 1'b0;
  logic [7:0] match_val = '0, byte_rx = 8'hFF;
  logic byte_req, done, timeout;
  logic [7:0] byte_tx;
  logic [39:0] resp;

  int nchk = 0, nfail = 0, nb = 0, dcount = 0;
  logic [7:0] script [64];
  logic [7:0] txlog [64];

  sd_spi_cmd_engine #(.POLL_LIMIT(8), .BUSY_LIMIT(BL)) i_sd_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .resp_len(resp_len), .match_en(match_en), .match_val(match_val), .busy_wait(busy_wait),
    .byte_req(byte_req), .byte_tx(byte_tx), .byte_ack(byte_ack), .byte_rx(byte_rx),
    .resp(resp), .done(done), .timeout(timeout));

  always #2.5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    if (done) dcount++;
    if (byte_ack) byte_ack = 1'b0;
    else if (byte_req) begin
      if (nb < 64) begin
        txlog[nb] = byte_tx;
        byte_rx = script[nb];
      end else byte_rx = 8'h00;
      nb++;
      byte_ack = 1'b1;
    end
  end

  initial begin
    #500000;
    nfail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  function automatic logic [7:0] crc_byte(input logic [7:0] b [5]);
    logic [6:0] r = '0;
    for (int k = 0; k < 5; k++)
      for (int i = 7; i >= 0; i--) begin
        logic fb;
        fb = r[6] ^ b[k][i];
        r = {r[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
      end
    return {r, 1'b1};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_script();
    for (int i = 0; i < 64; i++) begin
      script[i] = 8'hFF;
      txlog[i] = 8'h00;
    end
    nb = 0;
  endtask

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [2:0] len,
                       input logic men, input logic [7:0] mv, input logic bw);
    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; resp_len = len; match_en = men; match_val = mv; busy_wait = bw;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    while (dcount == d0) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R11 one done", 64'(dcount - d0), 64'd1);
  endtask

  task automatic check_frame(input logic [5:0] idx, input logic [31:0] arg, input string tag);
    logic [7:0] b [5];
    b[0] = {2'b01, idx}; b[1] = arg[31:24]; b[2] = arg[23:16]; b[3] = arg[15:8]; b[4] = arg[7:0];
    chk({"R1 filler ", tag}, 64'(txlog[0]), 64'hFF);
    for (int i = 0; i < 5; i++) chk({"R1 frame ", tag}, 64'(txlog[i+1]), 64'(b[i]));
    chk({"R2 crc ", tag}, 64'(txlog[6]), 64'(crc_byte(b)));
  endtask

  task automatic check_fill(input int n);
    for (int i = 7; i < n; i++) chk("R10 filler after frame", 64'(txlog[i]), 64'hFF);
  endtask

  task automatic t_reset();
    chk("R12 req", 64'(byte_req), 64'd0);
    chk("R12 done", 64'(done), 64'd0);
    chk("R12 timeout", 64'(timeout), 64'd0);
    chk("R12 resp", 64'(resp), 64'd0);
  endtask

  task automatic t_cmd0();
    int d0;
    clear_script(); script[7] = 8'h00; script[8] = 8'hFF; script[9] = 8'h01;
    d0 = dcount;
    issue(6'd0, 32'h0, 3'd1, 1'b0, 8'h00, 1'b0);
    wait_done(d0);
    check_frame(6'd0, 32'h0, "cmd0");
    chk("R2 cmd0 literal", 64'(txlog[6]), 64'h95);
    chk("R3 R4 resp", 64'(resp), 64'h01_00000000);
    chk("R4 bytes", 64'(nb), 64'd10);
    chk("R6 no timeout", 64'(timeout), 64'd0);
    check_fill(nb);
  endtask

  task automatic t_match();
    int d0;
    clear_script(); script[8] = 8'h05; script[9] = 8'h01;
    script[10] = 8'h00; script[11] = 8'h00; script[12] = 8'h01; script[13] = 8'hAA;
    d0 = dcount;
    issue(6'd8, 32'h1AA, 3'd5, 1'b1, 8'h01, 1'b0);
    wait_done(d0);
    check_frame(6'd8, 32'h1AA, "cmd8");
    chk("R2 cmd8 literal", 64'(txlog[6]), 64'h87);
    chk("R5 R7 resp", 64'(resp), 64'h01_000001AA);
    chk("R5 bytes", 64'(nb), 64'd14);
  endtask

  task automatic t_timeout();
    int d0;
    clear_script(); script[16] = 8'h00;
    d0 = dcount;
    issue(6'd17, 32'h12345678, 3'd2, 1'b0, 8'h00, 1'b0);
    wait_done(d0);
    check_frame(6'd17, 32'h12345678, "cmd17");
    chk("R6 timeout", 64'(timeout), 64'd1);
    chk("R6 resp zero", 64'(resp), 64'd0);
    chk("R6 bytes", 64'(nb), 64'd16);
  endtask

  task automatic t_last_slot();
    int d0;
    clear_script(); script[15] = 8'h00;
    d0 = dcount;
    issue(6'd16, 32'h200, 3'd1, 1'b0, 8'h00, 1'b0);
    wait_done(d0);
    chk("R4 last slot timeout", 64'(timeout), 64'd0);
    chk("R4 last slot bytes", 64'(nb), 64'd16);
  endtask

  task automatic t_len2();
    int d0;
    clear_script(); script[9] = 8'h7E; script[10] = 8'h5A;
    d0 = dcount;
    issue(6'd13, 32'hDEADBEEF, 3'd2, 1'b0, 8'h00, 1'b0);
    wait_done(d0);
    check_frame(6'd13, 32'hDEADBEEF, "cmd13");
    chk("R7 len2 resp", 64'(resp), 64'h7E_5A000000);
    chk("R7 len2 bytes", 64'(nb), 64'd11);
    check_fill(nb);
  endtask

  task automatic t_busy();
    int d0;
    clear_script();
    for (int i = 8; i < 12; i++) script[i] = 8'h00;
    d0 = dcount;
    issue(6'd12, 32'h0, 3'd1, 1'b0, 8'h00, 1'b1);
    wait_done(d0);
    chk("R8 busy bytes", 64'(nb), 64'd13);
    chk("R8 busy timeout", 64'(timeout), 64'd0);
    chk("R8 busy resp", 64'(resp), 64'd0);
  endtask

  task automatic t_busy_to();
    int d0;
    clear_script(); script[8] = 8'h04;
    for (int i = 9; i < 64; i++) script[i] = 8'h00;
    d0 = dcount;
    issue(6'd38, 32'h0, 3'd1, 1'b0, 8'h00, 1'b1);
    wait_done(d0);
    chk("R9 timeout", 64'(timeout), 64'd1);
    chk("R9 bytes", 64'(nb), 64'(9 + BL));
    chk("R9 resp kept", 64'(resp), 64'h04_00000000);
  endtask

  task automatic t_start_ignored();
    int d0;
    clear_script(); script[8] = 8'h00;
    d0 = dcount;
    issue(6'd9, 32'hCAFE0001, 3'd1, 1'b0, 8'h00, 1'b0);
    repeat (4) @(negedge clk);
    cmd_idx = 6'd55; cmd_arg = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(d0);
    check_frame(6'd9, 32'hCAFE0001, "restart");
    chk("R11 bytes", 64'(nb), 64'd9);
    repeat (4) @(negedge clk);
    chk("R11 idle after", 64'(byte_req), 64'd0);
  endtask

  initial begin
    clear_script();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_cmd0();
    t_match();
    t_timeout();
    t_last_slot();
    t_len2();
    t_busy();
    t_busy_to();
    t_start_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule